// File: doc/BRIEF.md
# Tape Pulse-Width Classifier

The block watches the write line of a tape interface and measures the time between successive rising edges. The line first passes through a two-stage synchronizer and a noise filter. A rising edge counts only once the filtered level has been high for several samples in a row. A prescaler divides the clock by 64 and drives an 8-bit width timer. Each accepted rising edge captures the timer value and then clears both the timer and the prescaler, so every measurement starts from zero.

There are two modes. In raw mode the captured width is sent out unchanged as one byte. The timer stops at 255 and then reads zero. In classify mode the width becomes one of four ASCII letters, chosen with two thresholds. A separate limit value stops the timer early, so a gap longer than the limit reads as zero and is reported as a pause. If classify mode is selected while the short threshold is zero, the block acts exactly as in raw mode.

Each result leaves through a valid/ready port toward a serial transmitter. If a new result arrives while the port is stalled, the block keeps it in a one-entry side slot and raises a sticky overrun flag.

Top module: `pulse_width_classifier`

## Requirements
- R1: During and after reset, `outValid` is 0, `overrun` is 0 and `outData` is 0x00.
- R2: The measured width is the number of complete 64-clock prescaler periods between two accepted rising edges. In raw mode (`modeClassify`=0) the output byte equals that width.
- R3: In raw mode the timer stops when it would reach 255, so a width of 255 or more reads as 0x00. A width of 254 reads as 254.
- R4: In classify mode a width that reads zero is reported as the pause letter 'A' (0x41).
- R5: In classify mode a nonzero width below `thresh1` gives 'B' (0x42). Otherwise a width below `thresh2` gives 'C' (0x43). Otherwise the result is 'D' (0x44). A width equal to `thresh1` is not "below" it, so it gives 'C'.
- R6: In classify mode the timer stops when it would reach `limitCmp`, so a width at or above `limitCmp` reads zero and gives 'A'. A width of `limitCmp`-1 is classified normally.
- R7: Classify mode with `thresh1` = 0 behaves as raw mode: the output byte is the width, and the timer limit is 255, not `limitCmp`.
- R8: The input level changes only after 4 equal samples in a row. A high glitch of 3 clocks produces no byte and does not restart the width timer.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` holds its value.
- R10: A capture that arrives while the output is stalled sets `overrun`. `overrun` stays set until reset. The new result is kept and is delivered right after the stalled one, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tapeIn | input | 1 | Asynchronous tape write line |
| modeClassify | input | 1 | 1 = classify into letters, 0 = raw width |
| thresh1 | input | 8 | Short/medium boundary in prescaled ticks; 0 forces raw behaviour |
| thresh2 | input | 8 | Medium/long boundary in prescaled ticks |
| limitCmp | input | 8 | Classify-mode timer stop value |
| outReady | input | 1 | Downstream accepts the byte this cycle |
| outValid | output | 1 | A result byte is offered |
| outData | output | 8 | Result byte: raw width or letter |
| overrun | output | 1 | Sticky: a result arrived while the output was stalled |

## Verification
The assertions check every cycle that a stalled byte holds its value, that the overrun flag only rises after a cycle in which the output was full and not accepted, that it never clears on its own, and that stable classify settings only ever produce one of the four letters. Only the bench scenarios can show the actual width arithmetic: the period counting, the stop at 255 or at `limitCmp` that turns long gaps into zero, the threshold boundaries, and the fall-back to raw behaviour when `thresh1` is zero. Noise rejection and the in-order delivery of the result held back during a stall also rely on directed stimulus at the tape input.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
package pwc_pkg;

  localparam logic [7:0] SYM_PAUSE  = 8'h41;
  localparam logic [7:0] SYM_SHORT  = 8'h42;
  localparam logic [7:0] SYM_MEDIUM = 8'h43;
  localparam logic [7:0] SYM_LONG   = 8'h44;

  typedef enum logic [1:0] {
    CLS_PAUSE,
    CLS_SHORT,
    CLS_MEDIUM,
    CLS_LONG
  } widthClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearTimer;   // accepted edge: capture and restart timing
    logic loadOutNew;   // fresh result goes straight to the output
    logic loadPendNew;  // fresh result goes to the side slot
    logic movePend;     // side slot moves to the output
  } dpStrobes_t;

  function automatic logic [7:0] symbolOf(widthClass_e cls);
    case (cls)
      CLS_PAUSE:  symbolOf = SYM_PAUSE;
      CLS_SHORT:  symbolOf = SYM_SHORT;
      CLS_MEDIUM: symbolOf = SYM_MEDIUM;
      default:    symbolOf = SYM_LONG;
    endcase
  endfunction

endpackage

// File: rtl/pwc_edge_filter.sv
`timescale 1ns/1ps
module pwc_edge_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tapeIn,
  output logic riseStb
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILTER_LEN-1:0]  histQ;
  logic                   levelQ;
  logic                   allHigh;
  logic                   allLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], tapeIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histQ <= '0;
    end else begin
      histQ <= {histQ[FILTER_LEN-2:0], syncQ[SYNC_STAGES-1]};
    end
  end

  assign allHigh = &histQ;
  assign allLow  = ~|histQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= 1'b0;
    end else if (allHigh) begin
      levelQ <= 1'b1;
    end else if (allLow) begin
      levelQ <= 1'b0;
    end
  end

  assign riseStb = allHigh && !levelQ;

endmodule

// File: rtl/pwc_ctrl.sv
`timescale 1ns/1ps
module pwc_ctrl
  import pwc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       riseStb,
  input  logic       outReady,
  output dpStrobes_t strobes,
  output logic       outValid,
  output logic       overrun
);

  logic validQ;
  logic pendValidQ;
  logic overrunQ;
  logic consume;
  logic stalledCapture;

  assign consume        = validQ && outReady;
  assign stalledCapture = riseStb && validQ && !outReady;

  always_comb begin
    strobes            = '0;
    strobes.clearTimer = riseStb;
    if (riseStb) begin
      if (!validQ || (consume && !pendValidQ)) begin
        strobes.loadOutNew = 1'b1;
      end else if (consume && pendValidQ) begin
        strobes.movePend    = 1'b1;
        strobes.loadPendNew = 1'b1;
      end else if (!pendValidQ) begin
        strobes.loadPendNew = 1'b1;
      end
    end else if (consume && pendValidQ) begin
      strobes.movePend = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ     <= 1'b0;
      pendValidQ <= 1'b0;
      overrunQ   <= 1'b0;
    end else begin
      validQ     <= (validQ && !consume) || strobes.loadOutNew || strobes.movePend;
      pendValidQ <= (pendValidQ && !strobes.movePend) || strobes.loadPendNew;
      if (stalledCapture) begin
        overrunQ <= 1'b1;
      end
    end
  end

  assign outValid = validQ;
  assign overrun  = overrunQ;

endmodule

// File: rtl/pwc_datapath.sv
`timescale 1ns/1ps
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int PRESCALE = 64,
  parameter int TIMER_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strobes,
  input  logic               modeClassify,
  input  logic [TIMER_W-1:0] thresh1,
  input  logic [TIMER_W-1:0] thresh2,
  input  logic [TIMER_W-1:0] limitCmp,
  output logic [7:0]         outData
);

  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0]    psQ;
  logic [TIMER_W-1:0] timerQ;
  logic               stoppedQ;
  logic [7:0]         outQ;
  logic [7:0]         pendQ;

  logic               classifyEff;
  logic [TIMER_W-1:0] cmpEff;
  logic [TIMER_W-1:0] timerInc;
  logic               tick;
  widthClass_e        widthCls;
  logic [7:0]         newByte;

  // Zero short threshold falls back to raw behaviour
  assign classifyEff = modeClassify && (thresh1 != '0);
  assign cmpEff      = classifyEff ? limitCmp : '1;
  assign timerInc    = timerQ + 1'b1;
  assign tick        = (psQ == PS_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psQ      <= '0;
      timerQ   <= '0;
      stoppedQ <= 1'b0;
    end else if (strobes.clearTimer) begin
      psQ      <= '0;
      timerQ   <= '0;
      stoppedQ <= 1'b0;
    end else if (!stoppedQ) begin
      psQ <= tick ? '0 : psQ + 1'b1;
      if (tick) begin
        if (timerInc == cmpEff) begin
          timerQ   <= '0;
          stoppedQ <= 1'b1;
        end else begin
          timerQ <= timerInc;
        end
      end
    end
  end

  always_comb begin
    if (timerQ == '0) begin
      widthCls = CLS_PAUSE;
    end else if (timerQ < thresh1) begin
      widthCls = CLS_SHORT;
    end else if (timerQ < thresh2) begin
      widthCls = CLS_MEDIUM;
    end else begin
      widthCls = CLS_LONG;
    end
  end

  assign newByte = classifyEff ? symbolOf(widthCls) : 8'(timerQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ  <= '0;
      pendQ <= '0;
    end else begin
      if (strobes.loadOutNew) begin
        outQ <= newByte;
      end else if (strobes.movePend) begin
        outQ <= pendQ;
      end
      if (strobes.loadPendNew) begin
        pendQ <= newByte;
      end
    end
  end

  assign outData = outQ;

endmodule

// File: rtl/pulse_width_classifier.sv
`timescale 1ns/1ps
module pulse_width_classifier
  import pwc_pkg::*;
#(
  parameter int PRESCALE    = 64,
  parameter int TIMER_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tapeIn,
  input  logic               modeClassify,
  input  logic [TIMER_W-1:0] thresh1,
  input  logic [TIMER_W-1:0] thresh2,
  input  logic [TIMER_W-1:0] limitCmp,
  input  logic               outReady,
  output logic               outValid,
  output logic [7:0]         outData,
  output logic               overrun
);

  logic       riseStb;
  dpStrobes_t strobes;

  pwc_edge_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILTER_LEN  (FILTER_LEN)
  ) u_filter (
    .clk     (clk),
    .rstN    (rstN),
    .tapeIn  (tapeIn),
    .riseStb (riseStb)
  );

  pwc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .riseStb  (riseStb),
    .outReady (outReady),
    .strobes  (strobes),
    .outValid (outValid),
    .overrun  (overrun)
  );

  pwc_datapath #(
    .PRESCALE (PRESCALE),
    .TIMER_W  (TIMER_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .modeClassify (modeClassify),
    .thresh1      (thresh1),
    .thresh2      (thresh2),
    .limitCmp     (limitCmp),
    .outData      (outData)
  );

endmodule

// File: rtl/pulse_width_classifier_chk.sv
`timescale 1ns/1ps
module pulse_width_classifier_chk #(
  parameter int TIMER_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               modeClassify,
  input logic [TIMER_W-1:0] thresh1,
  input logic               outReady,
  input logic               outValid,
  input logic [7:0]         outData,
  input logic               overrun
);

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R9

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun); // R10

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(outValid && !outReady)); // R10

  AST_LETTER_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && modeClassify && (thresh1 != '0) && $stable(modeClassify) && $stable(thresh1))
      |-> (outData >= 8'h41 && outData <= 8'h44)); // R5

endmodule

bind pulse_width_classifier pulse_width_classifier_chk #(.TIMER_W(TIMER_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .modeClassify (modeClassify),
  .thresh1      (thresh1),
  .outReady     (outReady),
  .outValid     (outValid),
  .outData      (outData),
  .overrun      (overrun)
);

// File: tb/tb_pulse_width_classifier.sv
`timescale 1ns/1ps
module tb_pulse_width_classifier;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tapeIn = 1'b0;
  logic       modeClassify = 1'b0;
  logic [7:0] thresh1 = '0;
  logic [7:0] thresh2 = '0;
  logic [7:0] limitCmp = '0;
  logic       outReady = 1'b1;
  logic       outValid;
  logic [7:0] outData;
  logic       overrun;

  int checks = 0;
  int errors = 0;
  int byteCount = 0;
  logic [7:0] lastByte = '0;
  logic [7:0] prevByte = '0;

  always #2 clk = ~clk;

  pulse_width_classifier dut (
    .clk(clk), .rstN(rstN), .tapeIn(tapeIn), .modeClassify(modeClassify),
    .thresh1(thresh1), .thresh2(thresh2), .limitCmp(limitCmp),
    .outReady(outReady), .outValid(outValid), .outData(outData), .overrun(overrun)
  );

  // Handshake monitor, 1 ns after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (outValid && outReady) begin
      prevByte  = lastByte;
      lastByte  = outData;
      byteCount = byteCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {req[4], mode[1], t1[8], t2[8], cmp[8], ticks[16], expected[8]}
  localparam int NV = 16;
  localparam logic [52:0] VEC [NV] = '{
    {4'd2,  1'b0, 8'd0, 8'd0,  8'd0,  16'd5,   8'd5},    // R2
    {4'd2,  1'b0, 8'd0, 8'd0,  8'd0,  16'd0,   8'd0},    // R2
    {4'd2,  1'b0, 8'd0, 8'd0,  8'd0,  16'd200, 8'd200},  // R2
    {4'd3,  1'b0, 8'd0, 8'd0,  8'd0,  16'd254, 8'd254},  // R3
    {4'd3,  1'b0, 8'd0, 8'd0,  8'd0,  16'd255, 8'd0},    // R3
    {4'd3,  1'b0, 8'd0, 8'd0,  8'd0,  16'd300, 8'd0},    // R3
    {4'd4,  1'b1, 8'd3, 8'd6,  8'd10, 16'd0,   8'h41},   // R4
    {4'd5,  1'b1, 8'd3, 8'd6,  8'd10, 16'd2,   8'h42},   // R5
    {4'd5,  1'b1, 8'd3, 8'd6,  8'd10, 16'd3,   8'h43},   // R5
    {4'd5,  1'b1, 8'd3, 8'd6,  8'd10, 16'd5,   8'h43},   // R5
    {4'd5,  1'b1, 8'd3, 8'd6,  8'd10, 16'd6,   8'h44},   // R5
    {4'd6,  1'b1, 8'd3, 8'd6,  8'd10, 16'd9,   8'h44},   // R6
    {4'd6,  1'b1, 8'd3, 8'd6,  8'd10, 16'd10,  8'h41},   // R6
    {4'd6,  1'b1, 8'd3, 8'd6,  8'd10, 16'd40,  8'h41},   // R6
    {4'd7,  1'b1, 8'd0, 8'd6,  8'd10, 16'd12,  8'd12},   // R7
    {4'd5,  1'b1, 8'd1, 8'd2,  8'd20, 16'd1,   8'h43}    // R5
  };

  function automatic int spanOf(input int ticks);
    return 64 * ticks + 32;
  endfunction

  bit done = 0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    waitCyc(5);
    // R1: reset state
    check(outValid == 1'b0 && overrun == 1'b0 && outData == 8'h00, "R1 reset outputs",
          {outValid, overrun, outData}, 0);
    rstN = 1'b1;
    waitCyc(20);

    // Priming edge starts the first measured interval
    tapeIn = 1'b1;
    waitCyc(12);

    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      v            = VEC[i];
      modeClassify = v[48];
      thresh1      = v[47:40];
      thresh2      = v[39:32];
      limitCmp     = v[31:24];
      waitCyc(4);
      tapeIn = 1'b0;
      waitCyc(spanOf(int'(v[23:8])) - 16);
      tapeIn = 1'b1;
      cnt = byteCount;
      waitCyc(12);
      check(byteCount == cnt + 1, $sformatf("R%0d vector %0d byte count", v[52:49], i),
            byteCount - cnt, 1);
      check(lastByte == v[7:0], $sformatf("R%0d vector %0d value", v[52:49], i),
            lastByte, v[7:0]);
    end

    // R8: a 3-clock glitch is rejected and does not restart timing
    modeClassify = 1'b0;
    waitCyc(4);
    tapeIn = 1'b0;
    waitCyc(100);
    cnt = byteCount;
    tapeIn = 1'b1;
    waitCyc(3);
    tapeIn = 1'b0;
    waitCyc(20);
    check(byteCount == cnt, "R8 glitch produced no byte", byteCount - cnt, 0);
    waitCyc(spanOf(7) - 139);
    tapeIn = 1'b1;
    waitCyc(12);
    check(byteCount == cnt + 1 && lastByte == 8'd7, "R8 width spans glitch", lastByte, 7);

    // R9 / R10: stall the output across two captures
    outReady = 1'b0;
    waitCyc(4);
    tapeIn = 1'b0;
    waitCyc(spanOf(3) - 16);
    tapeIn = 1'b1;
    cnt = byteCount;
    waitCyc(12);
    check(outValid == 1'b1 && outData == 8'd3 && overrun == 1'b0, "R9 byte offered while stalled",
          outData, 3);
    waitCyc(4);
    tapeIn = 1'b0;
    waitCyc(100);
    check(outValid == 1'b1 && outData == 8'd3, "R9 byte held while stalled", outData, 3);
    waitCyc(spanOf(4) - 116);
    tapeIn = 1'b1;
    waitCyc(12);
    check(overrun == 1'b1, "R10 overrun raised", overrun, 1);
    check(outData == 8'd3 && byteCount == cnt, "R10 stalled byte not overwritten", outData, 3);
    outReady = 1'b1;
    waitCyc(4);
    check(byteCount == cnt + 2, "R10 both bytes delivered", byteCount - cnt, 2);
    check(prevByte == 8'd3 && lastByte == 8'd4, "R10 delivery order",
          {prevByte, lastByte}, {8'd3, 8'd4});
    check(overrun == 1'b1 && outValid == 1'b0, "R10 overrun sticky", overrun, 1);

    // R1: reset clears the sticky flag
    rstN = 1'b0;
    waitCyc(2);
    check(overrun == 1'b0 && outValid == 1'b0 && outData == 8'h00, "R1 reset clears state",
          {outValid, overrun, outData}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule